// File: doc/BRIEF.md
# Interrupt Exception Entry Sequencer

This block sits beside a processor core and turns pending interrupt requests into the exception entry sequence. Requests come from one non-maskable line and from a parameterized set of maskable sources, each with a four-bit priority level. Each maskable source is either an on-chip peripheral or an external pin, chosen by a parameter. A source whose routing input sends it to a DMA or transfer controller takes no part in arbitration. Among the rest, the request with the highest level wins, provided that level is above the current mask. The non-maskable line is always taken and beats every maskable source.

Once a winner is latched, the block spends the judgment and compare states for its class. It then waits for the core to finish its current sequence and performs the entry: it saves the status word, saves the program counter, reads the handler address from a vector table, loads the program counter and mask level, and signals the start of the first handler fetch. Memory traffic uses a request/acknowledge port, so the memory side sets the number of wait states for every access.

Top module: `intr_entry_seq`

## Requirements
- R1: After reset, and at once while reset is asserted (also in the middle of a sequence), `busy`, `mem_req`, `pc_load`, `mask_load` and `fetch_go` are low.
- R2: Among eligible maskable sources, the one with the highest level wins. On equal levels the lower source index wins. Source i uses vector number `SRC_VEC0 + i`.
- R3: A maskable request is accepted only when its level is strictly greater than `sr_mask`. A request with a level equal to or below the mask starts no sequence: `busy` and `mem_req` stay low.
- R4: `nmi_req` is accepted whatever the value of `sr_mask`, and it beats all maskable sources. It uses vector number `NMI_VEC`, and it raises the mask to all ones (15).
- R5: A source whose `src_to_dma` bit is set is ignored by the arbitration. A lower-level source that is eligible is taken instead, and if no source is eligible nothing starts.
- R6: Entry performs exactly three accesses, in this order:
  - a write of the latched `cur_sr` to `cur_sp - 4`;
  - a write of the latched `cur_pc` to `cur_sp - 8`;
  - a read (`mem_we` low) from `vec_base + 4 * vector`.
- R7: During an access, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay constant until the cycle in which `mem_ack` is high. Each wait state adds one cycle.
- R8: Count the clock edge that first samples the request as edge 0, and let m1, m2 and m3 be the cycles each access takes, including its acknowledge cycle. With the core not busy, `fetch_go` rises after edge P + 5 + m1 + m2 + m3. P is 2 for peripheral and non-maskable sources and 4 for pin sources, so single-cycle memory gives 10 and 12.
- R9: `cpu_busy` is sampled once the compare states end. While it is high the entry does not begin. If it is first sampled low at edge j > P, `fetch_go` rises after edge j + 5 + m1 + m2 + m3.
- R10: `pc_load` and `mask_load` pulse for one cycle, two cycles before `fetch_go`. At that point `new_pc` equals the data returned by the vector read, and `new_mask` equals the accepted level. `fetch_go` lasts one cycle and `busy` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nmi_req | input | 1 | Non-maskable request |
| src_req | input | NSRC | Maskable request per source |
| src_lvl | input | NSRC*LW | Priority level per source, source i at bits [i*LW +: LW] |
| src_to_dma | input | NSRC | Source is routed to a DMA or transfer controller |
| sr_mask | input | LW | Current mask level from the status register |
| cur_sr | input | DW | Status word to save |
| cur_pc | input | DW | Program counter to save |
| cur_sp | input | AW | Stack pointer before entry |
| vec_base | input | AW | Vector table base address |
| cpu_busy | input | 1 | Core is still inside its current sequence |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Access address |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | DW | Read data, valid with mem_ack |
| pc_load | output | 1 | Load new_pc into the program counter |
| new_pc | output | DW | Handler address |
| mask_load | output | 1 | Load new_mask into the status register |
| new_mask | output | LW | Raised mask level |
| fetch_go | output | 1 | First handler fetch starts |
| busy | output | 1 | Sequence in progress |

## Verification
The bench targets the following corner cases, and what a faulty design would do on each:
- **Tie between equal levels.** Getting this wrong reads the wrong table slot.
- **Level exactly equal to the mask.** Getting this wrong starts a spurious entry.
- **Non-maskable request under a full mask.** Getting this wrong drops the request.
- **Source routed to DMA that carries the highest level.** Getting this wrong steals its transfer.

Latency is measured edge by edge for both source classes, with wait states and with a late-finishing core. An off-by-one in any state count, or a design that lets an address change before the acknowledge, shows up as a wrong edge number or a changed address. A reset in the middle of a sequence must clear the memory request at once.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;
   // Sequencer phases
   typedef enum logic [3:0] {
      ST_IDLE, ST_PRE, ST_WAIT, ST_EXPRE, ST_SSR, ST_SPC, ST_RVEC, ST_EXPOST, ST_FETCH
   } seq_state_e;

   // State counts per source class
   localparam int JUDGE_PER = 0;
   localparam int JUDGE_PIN = 1;
   localparam int CMP_PER   = 2;
   localparam int CMP_PIN   = 3;
   // Fixed overhead around the three accesses (3 + 2 = 5)
   localparam int EXPRE_N   = 3;
   localparam int EXPOST_N  = 2;
endpackage

// File: rtl/intr_seq_arb.sv
module intr_seq_arb #(
   parameter int NSRC    = 8,
   parameter int LW      = 4,
   parameter bit TIE_LOW = 1'b1,
   localparam int IW     = $clog2(NSRC)
) (
   input  logic              nmi_req,
   input  logic [NSRC-1:0]   src_req,
   input  logic [NSRC-1:0]   src_to_dma,
   input  logic [NSRC*LW-1:0] src_lvl,
   input  logic [LW-1:0]     sr_mask,
   output logic              win_valid,
   output logic              win_nmi,
   output logic [IW-1:0]     win_idx,
   output logic [LW-1:0]     win_lvl
);
   logic [NSRC-1:0] elig;
   logic            found;
   logic [IW-1:0]   best_i;
   logic [LW-1:0]   best_l;

   for (genvar g = 0; g < NSRC; g++) begin : g_elig
      assign elig[g] = src_req[g] && !src_to_dma[g] && (src_lvl[g*LW +: LW] > sr_mask);
   end

   if (TIE_LOW) begin : g_tie_low
      // strict compare keeps the first (lowest) index on a tie
      always_comb begin
         found  = 1'b0;
         best_i = '0;
         best_l = '0;
         for (int i = 0; i < NSRC; i++) begin
            if (elig[i] && (!found || src_lvl[i*LW +: LW] > best_l)) begin
               found  = 1'b1;
               best_i = IW'(i);
               best_l = src_lvl[i*LW +: LW];
            end
         end
      end
   end else begin : g_tie_high
      // non-strict compare lets the last (highest) index take a tie
      always_comb begin
         found  = 1'b0;
         best_i = '0;
         best_l = '0;
         for (int i = 0; i < NSRC; i++) begin
            if (elig[i] && (!found || src_lvl[i*LW +: LW] >= best_l)) begin
               found  = 1'b1;
               best_i = IW'(i);
               best_l = src_lvl[i*LW +: LW];
            end
         end
      end
   end

   assign win_nmi   = nmi_req;
   assign win_valid = nmi_req | found;
   assign win_idx   = best_i;
   assign win_lvl   = nmi_req ? '1 : best_l;
endmodule

// File: rtl/intr_seq_ctrl.sv
module intr_seq_ctrl
   import intr_seq_pkg::*;
#(
   parameter int LW = 4,
   parameter int DW = 32,
   parameter int VW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          win_valid,
   input  logic          win_pin,
   input  logic [LW-1:0] win_lvl,
   input  logic [VW-1:0] win_vec,
   input  logic          cpu_busy,
   input  logic          mem_ack,
   input  logic [DW-1:0] mem_rdata,
   output seq_state_e    state,
   output logic          snap,
   output logic          first_post,
   output logic [VW-1:0] vec_q,
   output logic [LW-1:0] lvl_q,
   output logic [DW-1:0] pc_new_q
);
   localparam int CW = 3;
   localparam logic [CW-1:0] PRE_PER_LAST = CW'(JUDGE_PER + CMP_PER - 1);
   localparam logic [CW-1:0] PRE_PIN_LAST = CW'(JUDGE_PIN + CMP_PIN - 1);
   localparam logic [CW-1:0] EXPRE_LAST   = CW'(EXPRE_N - 1);
   localparam logic [CW-1:0] EXPOST_LAST  = CW'(EXPOST_N - 1);

   seq_state_e    st_q;
   logic [CW-1:0] cnt_q;

   assign state      = st_q;
   assign snap       = ((st_q == ST_PRE) && (cnt_q == '0) && !cpu_busy) ||
                       ((st_q == ST_WAIT) && !cpu_busy);
   assign first_post = (st_q == ST_EXPOST) && (cnt_q == EXPOST_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         cnt_q    <= '0;
         vec_q    <= '0;
         lvl_q    <= '0;
         pc_new_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (win_valid) begin
               st_q  <= ST_PRE;
               cnt_q <= win_pin ? PRE_PIN_LAST : PRE_PER_LAST;
               vec_q <= win_vec;
               lvl_q <= win_lvl;
            end
            ST_PRE: if (cnt_q == '0) begin
               st_q  <= cpu_busy ? ST_WAIT : ST_EXPRE;
               cnt_q <= EXPRE_LAST;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
            ST_WAIT: if (!cpu_busy) begin
               st_q  <= ST_EXPRE;
               cnt_q <= EXPRE_LAST;
            end
            ST_EXPRE: if (cnt_q == '0) st_q <= ST_SSR;
                      else cnt_q <= cnt_q - 1'b1;
            ST_SSR: if (mem_ack) st_q <= ST_SPC;
            ST_SPC: if (mem_ack) st_q <= ST_RVEC;
            ST_RVEC: if (mem_ack) begin
               st_q     <= ST_EXPOST;
               pc_new_q <= mem_rdata;
               cnt_q    <= EXPOST_LAST;
            end
            ST_EXPOST: if (cnt_q == '0) st_q <= ST_FETCH;
                       else cnt_q <= cnt_q - 1'b1;
            ST_FETCH: st_q <= ST_IDLE;
            default:  st_q <= ST_IDLE;
         endcase
      end
   end

   // R9: once waiting, a still-busy core keeps the entry from starting
   a_r9_wait_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WAIT && cpu_busy) |=> (st_q == ST_WAIT));
endmodule

// File: rtl/intr_seq_addr.sv
module intr_seq_addr
   import intr_seq_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32,
   parameter int VW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          snap,
   input  seq_state_e    state,
   input  logic [VW-1:0] vec_q,
   input  logic [DW-1:0] cur_sr,
   input  logic [DW-1:0] cur_pc,
   input  logic [AW-1:0] cur_sp,
   input  logic [AW-1:0] vec_base,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata
);
   localparam logic [AW-1:0] LWORD = AW'(4);

   logic [DW-1:0] sr_q, pc_q;
   logic [AW-1:0] sp_q, vb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
         pc_q <= '0;
         sp_q <= '0;
         vb_q <= '0;
      end else if (snap) begin
         sr_q <= cur_sr;
         pc_q <= cur_pc;
         sp_q <= cur_sp;
         vb_q <= vec_base;
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      case (state)
         ST_SSR: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = sp_q - LWORD;
            mem_wdata = sr_q;
         end
         ST_SPC: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = sp_q - (LWORD << 1);
            mem_wdata = pc_q;
         end
         ST_RVEC: begin
            mem_req   = 1'b1;
            mem_addr  = vb_q + (AW'(vec_q) << 2);
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
   import intr_seq_pkg::*;
#(
   parameter int              NSRC         = 8,
   parameter int              LW           = 4,
   parameter int              AW           = 32,
   parameter int              DW           = 32,
   parameter int              VW           = 8,
   parameter int              NMI_VEC      = 11,
   parameter int              SRC_VEC0     = 64,
   parameter logic [NSRC-1:0] IRQ_PIN_MASK = 8'hF0,
   parameter bit              TIE_LOW      = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               nmi_req,
   input  logic [NSRC-1:0]    src_req,
   input  logic [NSRC*LW-1:0] src_lvl,
   input  logic [NSRC-1:0]    src_to_dma,
   input  logic [LW-1:0]      sr_mask,
   input  logic [DW-1:0]      cur_sr,
   input  logic [DW-1:0]      cur_pc,
   input  logic [AW-1:0]      cur_sp,
   input  logic [AW-1:0]      vec_base,
   input  logic               cpu_busy,
   output logic               mem_req,
   output logic               mem_we,
   output logic [AW-1:0]      mem_addr,
   output logic [DW-1:0]      mem_wdata,
   input  logic               mem_ack,
   input  logic [DW-1:0]      mem_rdata,
   output logic               pc_load,
   output logic [DW-1:0]      new_pc,
   output logic               mask_load,
   output logic [LW-1:0]      new_mask,
   output logic               fetch_go,
   output logic               busy
);
   localparam int IW = $clog2(NSRC);

   if (NSRC < 2 || NSRC > 32) begin : g_chk_nsrc
      $error("NSRC must lie in 2..32");
   end
   if (LW < 2) begin : g_chk_lw
      $error("LW must be at least 2");
   end
   if (AW < VW + 2) begin : g_chk_aw
      $error("AW too narrow for the vector table");
   end
   if (SRC_VEC0 + NSRC > (1 << VW) || NMI_VEC >= (1 << VW)) begin : g_chk_vec
      $error("vector numbers exceed VW");
   end

   logic          win_valid, win_nmi, win_pin;
   logic [IW-1:0] win_idx;
   logic [LW-1:0] win_lvl;
   logic [VW-1:0] win_vec, vec_q;
   logic          snap, first_post;
   seq_state_e    state;

   intr_seq_arb #(.NSRC(NSRC), .LW(LW), .TIE_LOW(TIE_LOW)) u_arb (
      .nmi_req(nmi_req), .src_req(src_req), .src_to_dma(src_to_dma),
      .src_lvl(src_lvl), .sr_mask(sr_mask),
      .win_valid(win_valid), .win_nmi(win_nmi), .win_idx(win_idx), .win_lvl(win_lvl));

   assign win_pin = !win_nmi && IRQ_PIN_MASK[win_idx];
   assign win_vec = win_nmi ? VW'(NMI_VEC) : VW'(SRC_VEC0) + VW'(win_idx);

   intr_seq_ctrl #(.LW(LW), .DW(DW), .VW(VW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_pin(win_pin),
      .win_lvl(win_lvl), .win_vec(win_vec), .cpu_busy(cpu_busy),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .state(state), .snap(snap),
      .first_post(first_post), .vec_q(vec_q), .lvl_q(new_mask), .pc_new_q(new_pc));

   intr_seq_addr #(.AW(AW), .DW(DW), .VW(VW)) u_addr (
      .clk(clk), .rst_n(rst_n), .snap(snap), .state(state), .vec_q(vec_q),
      .cur_sr(cur_sr), .cur_pc(cur_pc), .cur_sp(cur_sp), .vec_base(vec_base),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

   assign pc_load   = first_post;
   assign mask_load = first_post;
   assign fetch_go  = (state == ST_FETCH);
   assign busy      = (state != ST_IDLE);

   // R7: an unacknowledged access keeps every request field
   a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
   // R10: loads lead the fetch start by two cycles
   a_r10_load_before_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_go |-> $past(pc_load, 2));
   // R10: the fetch start ends the sequence
   a_r10_idle_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_go |=> !busy);
   // R4: a non-maskable request seen while idle always starts a sequence
   a_r4_nmi_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && nmi_req) |=> busy);
   // R3: an accepted maskable winner lies above the mask
   a_r3_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && win_valid && !win_nmi) |-> (win_lvl > sr_mask));
endmodule

// File: tb/intr_entry_seq_tb.sv
module intr_entry_seq_tb;
   localparam logic [31:0] SP  = 32'h0000_8000;
   localparam logic [31:0] SR  = 32'h0000_00A0;
   localparam logic [31:0] PC  = 32'h0000_2468;
   localparam logic [31:0] VBR = 32'h0000_1000;
   localparam logic [31:0] KEY = 32'h5A5A_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        nmi_req = 1'b0;
   logic [7:0]  src_req = '0;
   logic [31:0] src_lvl = '0;
   logic [7:0]  src_to_dma = '0;
   logic [3:0]  sr_mask = '0;
   logic        cpu_busy = 1'b0;
   logic        mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr, mem_wdata, mem_rdata, new_pc;
   logic        pc_load, mask_load, fetch_go, busy;
   logic [3:0]  new_mask;
   logic [1:0]  waits = '0;
   logic [1:0]  wcnt;
   int          total = 0;
   int          bad = 0;
   int          cyc = 0;

   always #5 clk = ~clk;

   intr_entry_seq u_dut (
      .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .src_req(src_req), .src_lvl(src_lvl),
      .src_to_dma(src_to_dma), .sr_mask(sr_mask), .cur_sr(SR), .cur_pc(PC), .cur_sp(SP),
      .vec_base(VBR), .cpu_busy(cpu_busy), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .pc_load(pc_load), .new_pc(new_pc), .mask_load(mask_load), .new_mask(new_mask),
      .fetch_go(fetch_go), .busy(busy));

   // memory model: ack after 'waits' extra cycles, read data derived from address
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  wcnt <= '0;
      else if (mem_req && mem_ack) wcnt <= '0;
      else if (mem_req)            wcnt <= wcnt + 1'b1;
   end
   assign mem_ack   = mem_req && (wcnt == waits);
   assign mem_rdata = mem_addr ^ KEY;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000) begin
         total++;
         bad++;
         $display("FAIL R1 watchdog act=%0d exp=%0d", cyc, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   typedef struct packed {
      logic [3:0]  rid;
      logic        nmi;
      logic [7:0]  req;
      logic [31:0] lvl;
      logic [7:0]  dma;
      logic [3:0]  mask;
      logic [1:0]  wt;
      logic [4:0]  bj;
      logic        take;
      logic        pin;
      logic [7:0]  vec;
      logic [3:0]  elvl;
   } row_t;

   localparam int NROW = 12;
   localparam row_t TBL [NROW] = '{
      // R8 peripheral, single-cycle memory -> 10
      '{4'd8, 1'b0, 8'h04, 32'h0000_0500, 8'h00, 4'd3, 2'd0, 5'd0, 1'b1, 1'b0, 8'd66, 4'd5},
      // R8 pin source -> 12
      '{4'd8, 1'b0, 8'h20, 32'h0070_0000, 8'h00, 4'd0, 2'd0, 5'd0, 1'b1, 1'b1, 8'd69, 4'd7},
      // R2 tie at level 9 between sources 1 and 3
      '{4'd2, 1'b0, 8'h4A, 32'h0400_9090, 8'h00, 4'd2, 2'd0, 5'd0, 1'b1, 1'b0, 8'd65, 4'd9},
      // R2 higher level on source 7 beats source 0
      '{4'd2, 1'b0, 8'h81, 32'hC000_0003, 8'h00, 4'd2, 2'd0, 5'd0, 1'b1, 1'b1, 8'd71, 4'd12},
      // R3 level equal to mask is ignored
      '{4'd3, 1'b0, 8'h10, 32'h0006_0000, 8'h00, 4'd6, 2'd0, 5'd0, 1'b0, 1'b0, 8'd0,  4'd0},
      // R5 routed source 3 skipped, source 2 taken
      '{4'd5, 1'b0, 8'h0C, 32'h0000_8200, 8'h08, 4'd1, 2'd0, 5'd0, 1'b1, 1'b0, 8'd66, 4'd2},
      // R4 NMI under full mask beats level 15 source
      '{4'd4, 1'b1, 8'h40, 32'h0F00_0000, 8'h00, 4'd15, 2'd0, 5'd0, 1'b1, 1'b0, 8'd11, 4'd15},
      // R7 two wait states per access
      '{4'd7, 1'b0, 8'h04, 32'h0000_0500, 8'h00, 4'd0, 2'd2, 5'd0, 1'b1, 1'b0, 8'd66, 4'd5},
      // R9 core busy until edge 9
      '{4'd9, 1'b0, 8'h20, 32'h0040_0000, 8'h00, 4'd0, 2'd0, 5'd9, 1'b1, 1'b1, 8'd69, 4'd4},
      // R5 only source routed away -> nothing
      '{4'd5, 1'b0, 8'h01, 32'h0000_0009, 8'h01, 4'd0, 2'd0, 5'd0, 1'b0, 1'b0, 8'd0,  4'd0},
      // R3 level 15 under mask 15 ignored
      '{4'd3, 1'b0, 8'h02, 32'h0000_00F0, 8'h00, 4'd15, 2'd0, 5'd0, 1'b0, 1'b0, 8'd0, 4'd0},
      // R4 NMI alone with one wait state
      '{4'd4, 1'b1, 8'h00, 32'h0000_0000, 8'h00, 4'd0, 2'd1, 5'd0, 1'b1, 1'b0, 8'd11, 4'd15}
   };

   task automatic run_row(input row_t r);
      int lat, nacc, pl_at, p, expl, holderr;
      logic [31:0] a_addr [3];
      logic [31:0] a_dat [3];
      logic        a_we [3];
      logic [31:0] pl_pc, prev_addr;
      logic [3:0]  ml_val;
      logic        prev_pend, saw_busy;
      string       tg;
      tg = $sformatf("R%0d", r.rid);
      @(negedge clk);
      nmi_req = r.nmi; src_req = r.req; src_lvl = r.lvl; src_to_dma = r.dma;
      sr_mask = r.mask; waits = r.wt; cpu_busy = (r.bj > 0);
      lat = -1; nacc = 0; pl_at = -1; holderr = 0; prev_pend = 1'b0; prev_addr = '0;
      saw_busy = 1'b0; pl_pc = '0; ml_val = '0;
      for (int i = 0; i < 3; i++) begin a_addr[i] = '0; a_dat[i] = '0; a_we[i] = 1'b0; end
      for (int k = 0; k < 40 && lat < 0; k++) begin
         @(posedge clk);
         @(negedge clk);
         cpu_busy = ((k + 1) < int'(r.bj));
         saw_busy |= busy | mem_req;
         if (prev_pend && mem_addr != prev_addr) holderr++;
         prev_pend = mem_req && !mem_ack;
         prev_addr = mem_addr;
         if (mem_req && mem_ack) begin
            if (nacc < 3) begin a_addr[nacc] = mem_addr; a_dat[nacc] = mem_wdata; a_we[nacc] = mem_we; end
            nacc++;
         end
         if (pc_load && mask_load) begin pl_at = k; pl_pc = new_pc; ml_val = new_mask; end
         if (fetch_go) lat = k;
         if (!r.take && k == 20) break;
      end
      nmi_req = 1'b0; src_req = '0; cpu_busy = 1'b0;
      if (!r.take) begin
         chk(!saw_busy && lat < 0, {tg, " no entry"}, {31'd0, saw_busy}, 32'd0);
      end else begin
         p    = r.pin ? 4 : 2;
         expl = ((int'(r.bj) > p) ? int'(r.bj) : p) + 5 + 3 * (int'(r.wt) + 1);
         chk(lat == expl, {tg, " R8 latency"}, lat, expl);
         chk(nacc == 3, {tg, " R6 access count"}, nacc, 3);
         chk(a_we[0] && a_addr[0] == SP - 4 && a_dat[0] == SR, {tg, " R6 sr save"}, a_addr[0], SP - 4);
         chk(a_we[1] && a_addr[1] == SP - 8 && a_dat[1] == PC, {tg, " R6 pc save"}, a_addr[1], SP - 8);
         chk(!a_we[2] && a_addr[2] == VBR + 4 * r.vec, {tg, " vector read"}, a_addr[2], VBR + 4 * r.vec);
         chk(pl_pc == ((VBR + 4 * r.vec) ^ KEY), {tg, " R10 new_pc"}, pl_pc, (VBR + 4 * r.vec) ^ KEY);
         chk(ml_val == r.elvl, {tg, " R10 new_mask"}, ml_val, r.elvl);
         chk(pl_at == lat - 2, {tg, " R10 load timing"}, pl_at, lat - 2);
         chk(holderr == 0, {tg, " R7 hold"}, holderr, 0);
         @(negedge clk);
         chk(!busy && !fetch_go, {tg, " R10 idle after fetch"}, {30'd0, busy, fetch_go}, 0);
      end
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy && !mem_req && !fetch_go && !pc_load && !mask_load, "R1 in reset",
          {27'd0, busy, mem_req, fetch_go, pc_load, mask_load}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!busy && !mem_req && !fetch_go, "R1 after reset", {29'd0, busy, mem_req, fetch_go}, 0);

      for (int n = 0; n < NROW; n++) run_row(TBL[n]);

      // R1 reset in mid-sequence clears outputs at once
      @(negedge clk);
      src_req = 8'h04; src_lvl = 32'h0000_0500; sr_mask = 4'd0; src_to_dma = '0; waits = 2'd3;
      repeat (7) @(negedge clk);
      chk(mem_req, "R1 precondition access pending", {31'd0, mem_req}, 1);
      rst_n = 1'b0;
      #1;
      chk(!busy && !mem_req && !fetch_go, "R1 mid-sequence reset", {29'd0, busy, mem_req, fetch_go}, 0);
      src_req = '0;
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!busy, "R1 stays idle after reset", {31'd0, busy}, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule